// File: doc/BRIEF.md
# Interrupt request flag controller

This block collects interrupt requests for a small 8-bit microcontroller core and presents two request lines to the CPU. The first is an external request. A falling edge on a dedicated interrupt pin latches it. When a configuration input allows it, a falling edge on any of a group of general port pins latches it too. The second request comes from a free-running core timer. The timer delivers one-cycle overflow and periodic-tick pulses, and each pulse latches its own flag. Each timer flag has its own enable bit.

Software reaches the flags through two byte-wide registers. Writes are strobed and reads are combinational. The external flag cannot be written. It is cleared either by a write-1 clear bit or by the CPU's vector-fetch acknowledge. The timer flags are cleared by write-1 bits. A global mask input from the CPU suppresses both request outputs but leaves the flags untouched. Software can therefore still poll the flags.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset all three flags and both enable bits are 0, both request outputs are 0, and both registers read 0x00.
- R2: A high-to-low change on `irq_pin` sets the external flag (bit 7 of the external register at address 0x0A). The flag becomes visible three clock edges after the pin change: two synchronizer flops plus the flag. Holding the pin low does not set the flag again after it has been cleared.
- R3: A high-to-low change on any `port_pin` bit sets the external flag with the same latency as R2, but only while `cfg_port_irq_en` is 1. While it is 0, port pin activity leaves the flag unchanged.
- R4: The external flag is read-only. Writing 1 to bit 7 of address 0x0A does not set it.
- R5: The external flag is cleared by a cycle with `vec_ack` high, or by a write with bit 1 of address 0x0A set. Writing 0 to bit 1 leaves the flag as it was, and bit 1 always reads 0.
- R6: When a flag's set event and a clear act in the same cycle, the flag ends the cycle set.
- R7: A one-cycle pulse on `tmr_ovf_pulse` sets the overflow flag, which reads at bit 7 of address 0x08. Writing 1 to bit 3 of 0x08 clears it. Bit 3 always reads 0.
- R8: A one-cycle pulse on `tmr_rti_pulse` sets the periodic flag, which reads at bit 6 of address 0x08. Writing 1 to bit 2 of 0x08 clears it. Bit 2 always reads 0.
- R9: The overflow enable (bit 5 of 0x08) and the periodic enable (bit 4 of 0x08) are read/write. Every write to 0x08 loads both. A timer flag stays set while its enable is 0.
- R10: `irq_tmr_req` is 1 exactly when `cpu_imask` is 0 and at least one timer flag is set together with its enable. `irq_ext_req` is 1 exactly when `cpu_imask` is 0 and the external flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_port_irq_en | input | 1 | Allows the port pins to act as external interrupt sources |
| irq_pin | input | 1 | Dedicated external interrupt pin, asynchronous, falling edge active |
| port_pin | input | N_PORT (4) | Port pins usable as extra external sources, asynchronous |
| tmr_ovf_pulse | input | 1 | One-cycle timer overflow event |
| tmr_rti_pulse | input | 1 | One-cycle periodic timer event |
| cpu_imask | input | 1 | CPU global interrupt mask |
| vec_ack | input | 1 | CPU fetch of the external interrupt vector |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W (8) | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for `addr` (combinational) |
| irq_ext_req | output | 1 | External interrupt request to the CPU |
| irq_tmr_req | output | 1 | Timer interrupt request to the CPU |

## Verification
The properties assume that the timer pulses and `vec_ack` are synchronous to `clk`, and that the pins reach the block only through its synchronizer. They also assume that `cfg_port_irq_en` is a quasi-static setting. The stimulus changes inputs only on falling clock edges and lets pins toggle at random. It changes the configuration input only rarely, so every set/clear overlap comes from cycle-aligned events. Random phases run against a bench-side reference that steps its own synchronizer copy of the pin values each cycle.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
   // external register fields
   localparam int unsigned EXT_FLAG_BIT = 7;
   localparam int unsigned EXT_CLR_BIT  = 1;
   // timer status/control register fields
   localparam int unsigned TMR_OVF_FLAG = 7;
   localparam int unsigned TMR_RTI_FLAG = 6;
   localparam int unsigned TMR_OVF_EN   = 5;
   localparam int unsigned TMR_RTI_EN   = 4;
   localparam int unsigned TMR_OVF_CLR  = 3;
   localparam int unsigned TMR_RTI_CLR  = 2;
   localparam int unsigned REG_W        = 8;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
   parameter int unsigned WIDTH  = 5,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pin,
   output logic [WIDTH-1:0] fall
);
   // stage 0..STAGES-1 synchronize, stage STAGES holds the previous value
   logic [WIDTH-1:0] stg [STAGES+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '1;
      else        stg[0] <= pin;
   end

   for (genvar i = 1; i <= STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[i] <= '1;
         else        stg[i] <= stg[i-1];
      end
   end

   assign fall = stg[STAGES] & ~stg[STAGES-1];
endmodule

// File: rtl/irq_flag_bit.sv
module irq_flag_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;   // set has priority over clear
      else if (clr) q <= 1'b0;
   end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
   import irq_flag_pkg::*;
#(
   parameter int unsigned N_PORT      = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned TMR_ADDR    = 8'h08,
   parameter int unsigned EXT_ADDR    = 8'h0A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_port_irq_en,
   input  logic              irq_pin,
   input  logic [N_PORT-1:0] port_pin,
   input  logic              tmr_ovf_pulse,
   input  logic              tmr_rti_pulse,
   input  logic              cpu_imask,
   input  logic              vec_ack,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   output logic [REG_W-1:0]  rdata,
   output logic              irq_ext_req,
   output logic              irq_tmr_req
);
   localparam int unsigned N_SRC = N_PORT + 1;

   // elaboration-time parameter checks
   if (N_PORT < 1)                 begin : g_bad_port  $error("N_PORT must be at least 1");        end
   if (SYNC_STAGES < 2)            begin : g_bad_sync  $error("SYNC_STAGES must be at least 2");   end
   if (TMR_ADDR == EXT_ADDR)       begin : g_bad_addr  $error("register addresses must differ");   end
   if (TMR_ADDR >= (1 << ADDR_W) || EXT_ADDR >= (1 << ADDR_W))
                                   begin : g_bad_range $error("address exceeds ADDR_W");           end

   logic [N_SRC-1:0] src_fall;
   logic             port_hit;
   logic             ext_set, ext_clr, ext_q;
   logic             ovf_clr, rti_clr, ovf_q, rti_q;
   logic             ovf_en_q, rti_en_q;
   logic             wr_ext, wr_tmr;
   logic             unused_wdata;

   irq_edge_sync #(.WIDTH(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   ({port_pin, irq_pin}),
      .fall  (src_fall)
   );

   assign port_hit = cfg_port_irq_en & (|src_fall[N_SRC-1:1]);
   assign ext_set  = src_fall[0] | port_hit;

   assign wr_ext  = wr_en && (addr == ADDR_W'(EXT_ADDR));
   assign wr_tmr  = wr_en && (addr == ADDR_W'(TMR_ADDR));
   assign ext_clr = vec_ack | (wr_ext & wdata[EXT_CLR_BIT]);
   assign ovf_clr = wr_tmr & wdata[TMR_OVF_CLR];
   assign rti_clr = wr_tmr & wdata[TMR_RTI_CLR];
   assign unused_wdata = ^wdata;

   irq_flag_bit u_ext (.clk(clk), .rst_n(rst_n), .set(ext_set),       .clr(ext_clr), .q(ext_q));
   irq_flag_bit u_ovf (.clk(clk), .rst_n(rst_n), .set(tmr_ovf_pulse), .clr(ovf_clr), .q(ovf_q));
   irq_flag_bit u_rti (.clk(clk), .rst_n(rst_n), .set(tmr_rti_pulse), .clr(rti_clr), .q(rti_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_en_q <= 1'b0;
         rti_en_q <= 1'b0;
      end else if (wr_tmr) begin
         ovf_en_q <= wdata[TMR_OVF_EN];
         rti_en_q <= wdata[TMR_RTI_EN];
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(EXT_ADDR)) begin
         rdata[EXT_FLAG_BIT] = ext_q;
      end else if (addr == ADDR_W'(TMR_ADDR)) begin
         rdata[TMR_OVF_FLAG] = ovf_q;
         rdata[TMR_RTI_FLAG] = rti_q;
         rdata[TMR_OVF_EN]   = ovf_en_q;
         rdata[TMR_RTI_EN]   = rti_en_q;
      end
   end

   assign irq_ext_req = ext_q & ~cpu_imask;
   assign irq_tmr_req = ((ovf_q & ovf_en_q) | (rti_q & rti_en_q)) & ~cpu_imask;
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic cpu_imask,
   input logic vec_ack,
   input logic tmr_ovf_pulse,
   input logic tmr_rti_pulse,
   input logic irq_ext_req,
   input logic irq_tmr_req,
   input logic ext_set,
   input logic ext_q,
   input logic ovf_q,
   input logic rti_q
);
   p_ovf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_ovf_pulse |=> ovf_q);

   p_rti_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_rti_pulse |=> rti_q);

   p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ext_set |=> ext_q);

   p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_ack && !ext_set) |=> !ext_q);

   p_ext_ro_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_q && !ext_set) |=> !ext_q);

   p_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_imask |-> (!irq_ext_req && !irq_tmr_req));

   p_req_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_tmr_req |-> (ovf_q || rti_q));
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cpu_imask     (cpu_imask),
   .vec_ack       (vec_ack),
   .tmr_ovf_pulse (tmr_ovf_pulse),
   .tmr_rti_pulse (tmr_rti_pulse),
   .irq_ext_req   (irq_ext_req),
   .irq_tmr_req   (irq_tmr_req),
   .ext_set       (ext_set),
   .ext_q         (ext_q),
   .ovf_q         (ovf_q),
   .rti_q         (rti_q)
);

// File: tb/irq_flag_ctrl_tb.sv
module irq_flag_ctrl_tb;
   localparam int unsigned NP   = 4;
   localparam logic [7:0]  A_T  = 8'h08;
   localparam logic [7:0]  A_E  = 8'h0A;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_port_irq_en = 1'b0;
   logic          irq_pin = 1'b1;
   logic [NP-1:0] port_pin = '1;
   logic          tmr_ovf_pulse = 1'b0, tmr_rti_pulse = 1'b0;
   logic          cpu_imask = 1'b0, vec_ack = 1'b0, wr_en = 1'b0;
   logic [7:0]    addr = 8'h00, wdata = 8'h00;
   logic [7:0]    rdata;
   logic          irq_ext_req, irq_tmr_req;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   irq_flag_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_port_irq_en(cfg_port_irq_en),
      .irq_pin(irq_pin), .port_pin(port_pin),
      .tmr_ovf_pulse(tmr_ovf_pulse), .tmr_rti_pulse(tmr_rti_pulse),
      .cpu_imask(cpu_imask), .vec_ack(vec_ack), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata),
      .irq_ext_req(irq_ext_req), .irq_tmr_req(irq_tmr_req)
   );

   // reference model built from the requirements
   logic [NP:0] m1, m2, m3;
   logic m_ext, m_ovf, m_rti, m_oe, m_re;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m1 <= '1; m2 <= '1; m3 <= '1;
         m_ext <= 0; m_ovf <= 0; m_rti <= 0; m_oe <= 0; m_re <= 0;
      end else begin
         logic [NP:0] f;
         logic wt, we;
         f  = m3 & ~m2;
         wt = wr_en && addr == A_T;
         we = wr_en && addr == A_E;
         m1 <= {port_pin, irq_pin}; m2 <= m1; m3 <= m2;
         if (f[0] || (cfg_port_irq_en && |f[NP:1])) m_ext <= 1;
         else if (vec_ack || (we && wdata[1]))    m_ext <= 0;
         if (tmr_ovf_pulse) m_ovf <= 1; else if (wt && wdata[3]) m_ovf <= 0;
         if (tmr_rti_pulse) m_rti <= 1; else if (wt && wdata[2]) m_rti <= 0;
         if (wt) begin m_oe <= wdata[5]; m_re <= wdata[4]; end
      end
   end

   function automatic logic [7:0] exp_rd(logic [7:0] a);
      if (a == A_E) return {m_ext, 7'b0};
      if (a == A_T) return {m_ovf, m_rti, m_oe, m_re, 4'b0};
      return 8'h00;
   endfunction

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
      end
   endtask

   task automatic step(int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd(logic [7:0] a, output logic [7:0] v);
      addr = a; #1; v = rdata;
   endtask

   task automatic wr(logic [7:0] a, logic [7:0] d);
      wr_en = 1; addr = a; wdata = d; step(); wr_en = 0;
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #3_000_000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
      end
   end

   initial begin
      logic [7:0] v;
      void'($urandom(32'h1F2E3D4C));
      step(3); rst_n = 1; step();
      // R1 reset state
      rd(A_E, v); chk("R1 ext reg", v, 8'h00);
      rd(A_T, v); chk("R1 tmr reg", v, 8'h00);
      chk("R1 reqs", {6'b0, irq_ext_req, irq_tmr_req}, 8'h00);
      // R4 write to flag bit is ignored
      wr(A_E, 8'h80); rd(A_E, v); chk("R4 flag not writable", v, 8'h00);
      // R2 falling edge latency
      irq_pin = 0; step(2); rd(A_E, v); chk("R2 before latency", v, 8'h00);
      step(); rd(A_E, v); chk("R2 flag set", v, 8'h80);
      chk("R10 ext req", {7'b0, irq_ext_req}, 8'h01);
      // R5 write-0 no effect, write-1 clear, clear bit reads 0
      wr(A_E, 8'h00); rd(A_E, v); chk("R5 write 0 keeps", v, 8'h80);
      wr(A_E, 8'h02); rd(A_E, v); chk("R5 write 1 clears, bit1 reads 0", v, 8'h00);
      step(5); rd(A_E, v); chk("R2 held low no retrigger", v, 8'h00);
      irq_pin = 1; step(4);
      // R3 port pins gated off
      cfg_port_irq_en = 0; port_pin[2] = 0; step(5);
      rd(A_E, v); chk("R3 ports ignored when disabled", v, 8'h00);
      port_pin[2] = 1; step(4);
      cfg_port_irq_en = 1; port_pin[0] = 0; step(3);
      rd(A_E, v); chk("R3 port sets flag", v, 8'h80);
      vec_ack = 1; step(); vec_ack = 0;
      rd(A_E, v); chk("R5 vector ack clears", v, 8'h00);
      port_pin[0] = 1; step(4);
      // R6 set wins over both clears
      irq_pin = 0; step(2);
      vec_ack = 1; wr(A_E, 8'h02); vec_ack = 0;
      rd(A_E, v); chk("R6 set beats clear", v, 8'h80);
      vec_ack = 1; step(); vec_ack = 0; irq_pin = 1; step(4);
      // timer flags
      tmr_ovf_pulse = 1; step(); tmr_ovf_pulse = 0;
      rd(A_T, v); chk("R7 ovf set", v, 8'h80);
      chk("R9 no req while disabled", {7'b0, irq_tmr_req}, 8'h00);
      tmr_rti_pulse = 1; step(); tmr_rti_pulse = 0;
      rd(A_T, v); chk("R8 rti set", v, 8'hC0);
      wr(A_T, 8'h20); rd(A_T, v); chk("R9 enable rw", v, 8'hE0);
      chk("R10 tmr req", {7'b0, irq_tmr_req}, 8'h01);
      cpu_imask = 1; #1; chk("R10 masked", {6'b0, irq_ext_req, irq_tmr_req}, 8'h00);
      cpu_imask = 0;
      wr(A_T, 8'h28); rd(A_T, v); chk("R7 ovf clear, bit3 reads 0", v, 8'h60);
      chk("R10 rti not enabled", {7'b0, irq_tmr_req}, 8'h00);
      tmr_rti_pulse = 1; wr(A_T, 8'h34); tmr_rti_pulse = 0;
      rd(A_T, v); chk("R6 rti set beats clear", v, 8'h70);
      chk("R10 rti enabled", {7'b0, irq_tmr_req}, 8'h01);
      wr(A_T, 8'h34); rd(A_T, v); chk("R8 rti clear, bit2 reads 0", v, 8'h30);
      wr(A_T, 8'h00);
      // random phase against the reference
      for (int c = 0; c < 4000; c++) begin
         logic [7:0] ea;
         ea = exp_rd(addr); #1;
         chk("R2/R3/R5/R7/R8/R9 random regs", rdata, ea);
         chk("R10 random reqs", {6'b0, irq_ext_req, irq_tmr_req},
             {6'b0, m_ext & ~cpu_imask,
              ((m_ovf & m_oe) | (m_rti & m_re)) & ~cpu_imask});
         if ($urandom_range(199) == 0) cfg_port_irq_en = ~cfg_port_irq_en;
         if ($urandom_range(5) == 0) irq_pin = ~irq_pin;
         for (int p = 0; p < NP; p++) if ($urandom_range(7) == 0) port_pin[p] = ~port_pin[p];
         tmr_ovf_pulse = ($urandom_range(7) == 0);
         tmr_rti_pulse = ($urandom_range(7) == 0);
         vec_ack   = ($urandom_range(15) == 0);
         cpu_imask = ($urandom_range(3) == 0);
         wr_en     = ($urandom_range(4) == 0);
         case ($urandom_range(2))
            0: addr = A_E;
            1: addr = A_T;
            default: addr = 8'($urandom_range(255));
         endcase
         wdata = 8'($urandom);
         step();
      end
      done = 1'b1;
      report();
   end
endmodule